// File: doc/BRIEF.md
# Sparsity-Map ReLU Feature Encoder

This block sits at the output of a convolution stage. It turns a raster-ordered stream of signed 16-bit feature-map pixels into a compressed form. Every pixel first goes through a rectifier. If pooling is selected, 2x2 max pooling is applied before the rectifier, and the pooled map is never written out in full. For each resulting pixel the block emits one presence bit into a bitmap stream. Only the non-zero pixels, kept at full precision, go onto a separate value stream. A zero pixel therefore costs one bit. A non-zero pixel costs its sixteen bits plus its presence bit.

Presence bits are packed into 16-bit words, filling from the least significant bit. The last word of a map is flushed early, with zeros in the unused bits, and is tagged as the final word. The number of non-zero pixels in the map is presented alongside that final word. Either output stream may apply backpressure. Backpressure holds the input off, and no data is lost or repeated.

Top module: `sm_relu_encoder`

## Requirements
- R1: A pixel whose value, read as two's complement, is zero or negative encodes as a bitmap bit of 0 and adds no value entry. A positive pixel encodes as bit 1 and its value passes unchanged.
- R2: Each output pixel contributes exactly one bitmap bit. Bit k (k = 0..15) of a bitmap word belongs to the k-th pixel of that group of sixteen output pixels, counted in output order.
- R3: The value stream carries exactly the non-zero output pixels, in output order, as 16-bit values.
- R4: When a map's pixel count is not a multiple of 16, its final bitmap word is sent with all bits above the last pixel set to 0. bmLast is 1 on the final bitmap word of a map and 0 on every other word.
- R5: nzCount equals the number of non-zero output pixels of the map while the word with bmLast = 1 is offered. The count restarts from zero for the next map.
- R6: With poolEn = 1 and a map COLS pixels wide with an even row count, each aligned 2x2 window yields one output pixel. That pixel is the rectified maximum of the window's four pixels, and windows come out in raster order.
- R7: While an output stream has valid high and ready low, its data, its valid and (for the bitmap) bmLast hold steady, and inReady is low. Across any pattern of backpressure, no entry is lost or duplicated.
- R8: After reset neither output stream is valid and inReady is high.
- R9: With poolEn = 0, every accepted input pixel yields exactly one output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| poolEn | input | 1 | 1 selects 2x2 max pooling before the rectifier; hold stable within a map |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Input pixel accepted when high with inValid |
| inData | input | 16 | Signed input pixel |
| inLast | input | 1 | Marks the final input pixel of a map |
| bmValid | output | 1 | Bitmap word valid |
| bmReady | input | 1 | Bitmap consumer ready |
| bmWord | output | 16 | Packed presence bits, first pixel in bit 0 |
| bmLast | output | 1 | Final bitmap word of the map |
| valValid | output | 1 | Value entry valid |
| valReady | input | 1 | Value consumer ready |
| valData | output | 16 | Non-zero pixel value |
| nzCount | output | 16 | Non-zero pixel count of the map, meaningful with the final word |

## Verification
Three events can land on the same accepted pixel: a value entry, the flush of a bitmap word (either the sixteenth bit or the end of the map), and the loading of the non-zero count. The bench provokes this with maps whose final pixel is positive and sits at bit 15 or at a partial position. It also sweeps map lengths one through twenty, so every end position in a word is reached. Each sweep runs under several backpressure patterns, so the coinciding loads meet a stalled output as well as a free one. Every stream is judged against a model built arithmetically in the bench: the full value list, each word, the last flags and the count must match.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // Per-pixel strobes from control to datapath
  typedef struct packed {
    logic emit;       // an output pixel is formed from this input pixel
    logic holdPair;   // capture left pixel of a horizontal pair
    logic storeLine;  // write pair maximum into the line buffer (top row)
    logic flushWord;  // move the packed bitmap word to the output
    logic lastOut;    // this output pixel is the final one of the map
  } smStrobe_t;
endpackage

// File: rtl/sm_ctl.sv
module sm_ctl
  import sm_pkg::*;
#(
  parameter int COLS   = 8,
  parameter int WORD_W = 16,
  localparam int COL_W  = $clog2(COLS),
  localparam int LINE_W = (COLS > 2) ? $clog2(COLS / 2) : 1,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              poolEn,
  input  logic              inValid,
  input  logic              inLast,
  input  logic              outFree,
  output logic              inReady,
  output smStrobe_t         strb,
  output logic [LINE_W-1:0] lineIdx,
  output logic [BIT_W-1:0]  bitIdx
);
  logic [COL_W-1:0] col;
  logic             rowOdd;
  logic             accept;
  logic             wordFull;

  assign inReady  = outFree;
  assign accept   = inValid & outFree;
  assign wordFull = (bitIdx == BIT_W'(WORD_W - 1));
  assign lineIdx  = LINE_W'(col >> 1);

  always_comb begin
    strb.emit      = accept & (~poolEn | (rowOdd & col[0]));
    strb.holdPair  = accept & poolEn & ~col[0];
    strb.storeLine = accept & poolEn & ~rowOdd & col[0];
    strb.lastOut   = strb.emit & inLast;
    strb.flushWord = strb.emit & (wordFull | inLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      col    <= '0;
      rowOdd <= 1'b0;
      bitIdx <= '0;
    end else begin
      if (accept) begin
        if (inLast) begin
          col    <= '0;
          rowOdd <= 1'b0;
        end else if (col == COL_W'(COLS - 1)) begin
          col    <= '0;
          rowOdd <= ~rowOdd;
        end else begin
          col <= col + 1'b1;
        end
      end
      if (strb.flushWord)
        bitIdx <= '0;
      else if (strb.emit)
        bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/sm_dp.sv
module sm_dp
  import sm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 16,
  parameter int COLS   = 8,
  parameter int CNT_W  = 16,
  localparam int HALF   = (COLS > 2) ? COLS / 2 : 2,
  localparam int LINE_W = (COLS > 2) ? $clog2(COLS / 2) : 1,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              poolEn,
  input  logic [DATA_W-1:0] inData,
  input  smStrobe_t         strb,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic              valReady,
  input  logic              bmReady,
  output logic              outFree,
  output logic              valValid,
  output logic [DATA_W-1:0] valData,
  output logic              bmValid,
  output logic [WORD_W-1:0] bmWord,
  output logic              bmLast,
  output logic [CNT_W-1:0]  nzCount
);
  logic [DATA_W-1:0] lineBuf [HALF];
  logic [DATA_W-1:0] pairReg;
  logic [DATA_W-1:0] pairMax;
  logic [DATA_W-1:0] pooled;
  logic [DATA_W-1:0] pixVal;
  logic              isNz;
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] packNext;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  cntNext;

  assign outFree = (~valValid | valReady) & (~bmValid | bmReady);

  always_comb begin
    pairMax  = ($signed(inData) > $signed(pairReg)) ? inData : pairReg;
    pooled   = ($signed(pairMax) > $signed(lineBuf[lineIdx])) ? pairMax : lineBuf[lineIdx];
    pixVal   = poolEn ? pooled : inData;
    isNz     = ~pixVal[DATA_W-1] & (|pixVal);
    packNext = packReg | (WORD_W'(isNz) << bitIdx);
    cntNext  = cntReg + CNT_W'(isNz);
  end

  // pooling storage: no reset needed, written before being read
  always_ff @(posedge clk) begin
    if (strb.holdPair) pairReg <= inData;
    if (strb.storeLine) lineBuf[lineIdx] <= pairMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valValid <= 1'b0;
      valData  <= '0;
      bmValid  <= 1'b0;
      bmWord   <= '0;
      bmLast   <= 1'b0;
      packReg  <= '0;
      cntReg   <= '0;
      nzCount  <= '0;
    end else begin
      if (strb.emit && isNz) begin
        valValid <= 1'b1;
        valData  <= pixVal;
      end else if (valReady) begin
        valValid <= 1'b0;
      end

      if (strb.flushWord) begin
        bmValid <= 1'b1;
        bmWord  <= packNext;
        bmLast  <= strb.lastOut;
        packReg <= '0;
      end else begin
        if (bmReady) bmValid <= 1'b0;
        if (strb.emit) packReg <= packNext;
      end

      if (strb.lastOut) begin
        nzCount <= cntNext;
        cntReg  <= '0;
      end else if (strb.emit) begin
        cntReg <= cntNext;
      end
    end
  end
endmodule

// File: rtl/sm_relu_encoder.sv
module sm_relu_encoder
  import sm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 16,
  parameter int COLS   = 8,
  parameter int CNT_W  = 16,
  localparam int LINE_W = (COLS > 2) ? $clog2(COLS / 2) : 1,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              poolEn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              bmValid,
  input  logic              bmReady,
  output logic [WORD_W-1:0] bmWord,
  output logic              bmLast,
  output logic              valValid,
  input  logic              valReady,
  output logic [DATA_W-1:0] valData,
  output logic [CNT_W-1:0]  nzCount
);
  smStrobe_t         strb;
  logic [LINE_W-1:0] lineIdx;
  logic [BIT_W-1:0]  bitIdx;
  logic              outFree;

  sm_ctl #(.COLS(COLS), .WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rstN(rstN), .poolEn(poolEn), .inValid(inValid), .inLast(inLast),
    .outFree(outFree), .inReady(inReady), .strb(strb), .lineIdx(lineIdx), .bitIdx(bitIdx)
  );

  sm_dp #(.DATA_W(DATA_W), .WORD_W(WORD_W), .COLS(COLS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .poolEn(poolEn), .inData(inData), .strb(strb),
    .lineIdx(lineIdx), .bitIdx(bitIdx), .valReady(valReady), .bmReady(bmReady),
    .outFree(outFree), .valValid(valValid), .valData(valData), .bmValid(bmValid),
    .bmWord(bmWord), .bmLast(bmLast), .nzCount(nzCount)
  );
endmodule

// File: rtl/sm_relu_encoder_chk.sv
module sm_relu_encoder_chk #(
  parameter int DATA_W = 16,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              valValid,
  input logic              valReady,
  input logic [DATA_W-1:0] valData,
  input logic              bmValid,
  input logic              bmReady,
  input logic [WORD_W-1:0] bmWord,
  input logic              bmLast
);
  // R7
  val_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    valValid && !valReady |=> valValid && $stable(valData));

  // R7
  bm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bmValid && !bmReady |=> bmValid && $stable(bmWord) && $stable(bmLast));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valValid && !valReady) || (bmValid && !bmReady) |-> !inReady);

  // R3
  val_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    valValid |-> !valData[DATA_W-1] && (valData != '0));

  // R8
  rst_idle_chk: assert property (@(posedge clk)
    !rstN |=> !valValid && !bmValid);
endmodule

bind sm_relu_encoder sm_relu_encoder_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .valValid(valValid), .valReady(valReady),
  .valData(valData), .bmValid(bmValid), .bmReady(bmReady), .bmWord(bmWord), .bmLast(bmLast)
);

// File: tb/sim_sm_relu_encoder.sv
`timescale 1ns/1ps
module sim_sm_relu_encoder;
  localparam int COLS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        poolEn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inData = '0;
  logic        inLast = 1'b0;
  logic        bmValid, bmLast, valValid;
  logic        bmReady = 1'b1;
  logic        valReady = 1'b1;
  logic [15:0] bmWord, valData, nzCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int stallMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int pix [0:255];
  int expVal[$];
  int expBm[$];
  int expCnt;
  int gotVal[$];
  int gotBm[$];
  int gotLast[$];
  int gotCnt;

  always #2 clk = ~clk;

  sm_relu_encoder #(.COLS(COLS)) u0 (
    .clk(clk), .rstN(rstN), .poolEn(poolEn), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .bmValid(bmValid), .bmReady(bmReady),
    .bmWord(bmWord), .bmLast(bmLast), .valValid(valValid), .valReady(valReady),
    .valData(valData), .nzCount(nzCount)
  );

  // backpressure patterns, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stallMode)
      0: begin valReady = 1'b1; bmReady = 1'b1; end
      1: begin valReady = lfsr[0]; bmReady = lfsr[3]; end
      default: begin valReady = lfsr[1] & lfsr[2]; bmReady = lfsr[5] | lfsr[7]; end
    endcase
  end

  // collectors: sample away from the edge; transfer happens at next edge
  always @(negedge clk) begin
    if (rstN && valValid && valReady) gotVal.push_back(int'($signed(valData)));
    if (rstN && bmValid && bmReady) begin
      gotBm.push_back(int'(bmWord));
      gotLast.push_back(int'(bmLast));
      if (bmLast) gotCnt = int'(nzCount);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fillPix(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      pix[i] = (((i * 7 + seed * 13) % 11) - 5) * 2979;
      if ((i + seed) % 9 == 0) pix[i] = 32767;
      if ((i + seed) % 13 == 0) pix[i] = -32768;
    end
  endtask

  task automatic buildExp(input int n, input bit pool);
    int outs[$];
    int word;
    outs = {};
    expVal = {};
    expBm = {};
    expCnt = 0;
    if (pool) begin
      for (int r = 0; r < n / COLS; r += 2)
        for (int c = 0; c < COLS; c += 2) begin
          int m;
          m = pix[r * COLS + c];
          if (pix[r * COLS + c + 1] > m) m = pix[r * COLS + c + 1];
          if (pix[(r + 1) * COLS + c] > m) m = pix[(r + 1) * COLS + c];
          if (pix[(r + 1) * COLS + c + 1] > m) m = pix[(r + 1) * COLS + c + 1];
          outs.push_back(m);
        end
    end else begin
      for (int i = 0; i < n; i++) outs.push_back(pix[i]);
    end
    word = 0;
    for (int i = 0; i < outs.size(); i++) begin
      if (outs[i] > 0) begin
        expVal.push_back(outs[i]);
        expCnt++;
        word = word | (1 << (i % 16));
      end
      if ((i % 16 == 15) || (i == outs.size() - 1)) begin
        expBm.push_back(word);
        word = 0;
      end
    end
  endtask

  task automatic sendMap(input int n);
    for (int i = 0; i < n; i++) begin
      bit acc;
      inValid = 1'b1;
      inData  = 16'(pix[i]);
      inLast  = (i == n - 1);
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        acc = inReady;
        @(posedge clk);
        #1;
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic runMap(input int n, input bit pool, input int mode, input string tag);
    int t;
    gotVal = {};
    gotBm = {};
    gotLast = {};
    gotCnt = -1;
    stallMode = mode;
    poolEn = pool;
    buildExp(n, pool);
    sendMap(n);
    t = 0;
    while ((gotBm.size() < expBm.size() || gotVal.size() < expVal.size()) && t < 3000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
    stallMode = 0;
    chk({tag, "/R3 value count"}, gotVal.size(), expVal.size());
    chk({tag, "/R2 word count"}, gotBm.size(), expBm.size());
    for (int i = 0; i < expVal.size() && i < gotVal.size(); i++)
      chk({tag, "/R3 value"}, gotVal[i], expVal[i]);
    for (int i = 0; i < expBm.size() && i < gotBm.size(); i++) begin
      chk({tag, "/R2 R4 word"}, gotBm[i], expBm[i]);
      chk({tag, "/R4 last flag"}, gotLast[i], (i == expBm.size() - 1) ? 1 : 0);
    end
    chk({tag, "/R5 count"}, gotCnt, expCnt);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 bmValid", int'(bmValid), 0);
    chk("R8 valValid", int'(valValid), 0);
    chk("R8 inReady", int'(inReady), 1);
    @(posedge clk);
    #1;

    // R1 boundary values; the last pixel is positive and fills bit 15
    pix[0] = -1; pix[1] = 0; pix[2] = 1; pix[3] = -32768;
    pix[4] = 32767; pix[5] = 0; pix[6] = 2; pix[7] = -2;
    pix[8] = 0; pix[9] = 0; pix[10] = 100; pix[11] = -100;
    pix[12] = 0; pix[13] = 5; pix[14] = -5; pix[15] = 7;
    runMap(16, 1'b0, 0, "R1 directed");
    runMap(16, 1'b0, 2, "R1 directed stalled");

    // R5 map of all zero or negative pixels
    for (int i = 0; i < 10; i++) pix[i] = (i % 2 == 0) ? 0 : -i;
    runMap(10, 1'b0, 1, "R5 empty");

    // R9 sweep of map lengths and backpressure patterns without pooling
    for (int mode = 0; mode < 3; mode++)
      for (int n = 1; n <= 20; n++) begin
        fillPix(n, n + mode);
        runMap(n, 1'b0, mode, "R9 sweep");
      end

    // R7 long maps of all positive pixels under heavy stall
    for (int i = 0; i < 40; i++) pix[i] = i + 1;
    runMap(40, 1'b0, 2, "R7 dense");

    // R6 pooling sweep over row counts and backpressure patterns
    for (int mode = 0; mode < 3; mode++)
      for (int rows = 2; rows <= 10; rows += 2) begin
        fillPix(rows * COLS, rows * 3 + mode);
        runMap(rows * COLS, 1'b1, mode, "R6 pool");
      end

    // R6 pooling where every window maximum is negative except one
    for (int i = 0; i < 4 * COLS; i++) pix[i] = -1 - i;
    pix[COLS + 5] = 9;
    runMap(4 * COLS, 1'b1, 1, "R6 sparse pool");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule